// File: doc/BRIEF.md
# Parallel/Serial-Load Shift Register

This block is a chain of storage stages, sixteen by default, that can capture a whole word at once and then send it out one bit at a time. It can also work as a serial-in, serial-out delay line. Every state change happens on the falling edge of the clock. A mode pin chooses between two operations on that edge. One copies the parallel word into every stage. The other moves the chain up by one position, with the serial input entering the bottom stage.

An active-low select pin gates both operations. While select is high, the stages keep their contents, whatever the mode pin and the clock do. The serial output is always the top stage, so a loaded word comes out most significant bit first. The select pin must only rise while the clock is low, because a rise while the clock is high can act as a false clock. The block checks this rule itself.

The stream here is a plain register chain with no flow control, so there is no valid/ready pairing. Back-pressure is applied by the user through the select pin: holding select high stalls the stream for as long as needed, and no bit is lost.

Top module: `pload_shreg`

## Requirements
- R1: State changes only on the falling clock edge. Between two falling edges, including across a rising edge, `ser_out` does not change.
- R2: While `sel_n` is 1 at a falling edge, every stage keeps its value for either value of `mode` and any `par_in` or `ser_in`.
- R3: With `sel_n`=0 and `mode`=1 at a falling edge, stage i takes `par_in[i]` for every i.
- R4: With `sel_n`=0 and `mode`=0 at a falling edge, stage 0 takes `ser_in` and stage i takes the old stage i-1.
- R5: `ser_out` equals stage WIDTH-1. After a load followed by shifts, the loaded word appears on `ser_out` most significant bit first, one bit per shift.
- R6: A bit placed on `ser_in` at one shift appears on `ser_out` after exactly WIDTH shifts in total.
- R7: `sel_n` may rise only while `clk` is 0. A rise while `clk` is 1 is flagged as a violation.
- R8: `rst_n`=0 clears every stage to 0 at once, without waiting for a clock edge, so `ser_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| sel_n | input | 1 | Active-low select; high holds the register |
| mode | input | 1 | 1 = parallel load, 0 = shift |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| ser_out | output | 1 | Top stage (WIDTH-1) |

## Verification
The assertions check on every falling edge that the stages hold while deselected, take the parallel word on a load, and move up by one on a shift. They also check that the output after a shift is the old second-highest stage. Another assertion checks each rise of select against the clock level. Only the bench scenarios can show the things these local checks cannot. These are the most-significant-first order of a full word across sixteen shifts, a single bit taking exactly WIDTH shifts to reach the output, a word surviving a long deselected stretch in which a load and a shift were both requested, the output staying still across rising edges, and an asynchronous clear in the middle of a stream.

// File: rtl/pload_shreg_pkg.sv
`timescale 1ns/1ps
package pload_shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } shreg_op_e;
endpackage

// File: rtl/pload_shreg_ctrl.sv
`timescale 1ns/1ps
module pload_shreg_ctrl
  import pload_shreg_pkg::*;
(
  input  logic      sel_n,
  input  logic      mode,
  output shreg_op_e op
);
  // select dominates: deselected means hold regardless of mode
  always_comb begin
    if (sel_n)     op = OP_HOLD;
    else if (mode) op = OP_LOAD;
    else           op = OP_SHIFT;
  end
endmodule

// File: rtl/pload_shreg_next.sv
`timescale 1ns/1ps
module pload_shreg_next
  import pload_shreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  shreg_op_e        op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] par,
  input  logic             sin,
  output logic [WIDTH-1:0] nxt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic below;
    if (i == 0) begin : g_bottom
      assign below = sin;
    end else begin : g_upper
      assign below = cur[i-1];
    end
    always_comb begin
      unique case (op)
        OP_LOAD:  nxt[i] = par[i];
        OP_SHIFT: nxt[i] = below;
        default:  nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/pload_shreg.sv
`timescale 1ns/1ps
module pload_shreg
  import pload_shreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out
);
  localparam int TOP = WIDTH - 1;

  shreg_op_e        op;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  pload_shreg_ctrl u_ctrl (
    .sel_n (sel_n),
    .mode  (mode),
    .op    (op)
  );

  pload_shreg_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (stage_q),
    .par (par_in),
    .sin (ser_in),
    .nxt (stage_d)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign ser_out = stage_q[TOP];

  // R2: deselected edge leaves every stage untouched
  p_hold_r2: assert property (@(negedge clk) disable iff (!rst_n)
    sel_n |=> $stable(stage_q))
    else $error("hold violated");

  // R3: load copies the whole word
  p_load_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (!sel_n && mode) |=> (stage_q == $past(par_in)))
    else $error("parallel load mismatch");

  // R4: shift moves chain up by one with serial bit at the bottom
  p_shift_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (!sel_n && !mode) |=> (stage_q == {$past(stage_q[TOP-1:0]), $past(ser_in)}))
    else $error("shift mismatch");

  // R5: after a shift the output shows what sat one stage below the top
  p_sout_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (!sel_n && !mode) |=> (ser_out == $past(stage_q[TOP-1])))
    else $error("serial output order wrong");

  // R7: select may only rise while the clock is low
  always @(posedge sel_n) begin
    if (rst_n === 1'b1) begin
      p_clk_low_on_deselect_r7: assert (clk == 1'b0)
        else $error("select rose while clock high");
    end
  end
endmodule

// File: tb/test_pload_shreg.sv
`timescale 1ns/1ps
module test_pload_shreg;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1;
  logic         mode = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  wire          ser_out;

  always #2.5 clk = ~clk;

  pload_shreg #(.WIDTH(W)) i_pload_shreg (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode(mode),
    .par_in(par_in), .ser_in(ser_in), .ser_out(ser_out)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  bit    mdl[$];      // front = top stage, back = stage 0
  bit    exp_q[$];
  string tag_q[$];
  logic  cur_exp = 1'b0;

  task automatic check(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  // driver: one falling edge per call, pushes the expected output
  task automatic cycle(input logic s_n, input logic m, input logic [W-1:0] p,
                       input logic si, input string tag);
    #0.5;
    sel_n = s_n; mode = m; par_in = p; ser_in = si;
    @(negedge clk);
    if (!s_n && m) begin
      mdl.delete();
      for (int i = W - 1; i >= 0; i--) mdl.push_back(p[i]);
    end else if (!s_n) begin
      void'(mdl.pop_front());
      mdl.push_back(si);
    end
    exp_q.push_back(mdl[0]);
    tag_q.push_back(tag);
  endtask

  task automatic load(input logic [W-1:0] p, input string tag);
    cycle(1'b0, 1'b1, p, 1'b0, tag);
  endtask

  task automatic shift_n(input int n, input logic si, input string tag);
    for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, '0, si, tag);
  endtask

  // monitor: compare after each falling edge, and after each rising edge
  always begin
    @(negedge clk);
    #1.5;
    if (exp_q.size() > 0) begin
      cur_exp = exp_q.pop_front();
      check(tag_q.pop_front(), ser_out, cur_exp);
    end
  end

  always begin
    @(posedge clk);
    #1;
    if (started && rst_n) check("R1 steady across rising edge", ser_out, cur_exp);
  end

  always @(posedge sel_n) begin
    if (started) begin
      checks++;
      if (clk !== 1'b0) begin
        fails++;
        $display("FAIL R7: clk=%b expected 0 when sel_n rose", clk);
      end
    end
  end

  initial begin
    for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 output zero in reset", ser_out, 1'b0);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    started = 1'b1;

    // R3 + R5: load then stream MSB first, refill with alternating bits
    load(16'hA5C3, "R3 load word");
    for (int k = 0; k < W; k++) cycle(1'b0, 1'b0, '0, k[0], "R5 MSB-first stream");
    shift_n(4, 1'b1, "R4 shift after refill");

    // R2: deselected while load and shift are requested
    load(16'h8001, "R3 load before hold");
    for (int k = 0; k < 5; k++) cycle(1'b1, 1'b1, 16'h7FFE, 1'b0, "R2 hold ignores load");
    for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, '0, 1'b1, "R2 hold ignores shift");
    shift_n(W, 1'b0, "R2 word kept through hold");

    // R4: interleaved loads and shifts
    load(16'h3C5A, "R3 second load");
    shift_n(3, 1'b1, "R4 partial shift");
    cycle(1'b1, 1'b0, '0, 1'b0, "R2 mid-stream pause");
    shift_n(W, 1'b0, "R4 drain");

    // R6: single marker bit through the delay line
    load('0, "R3 clear by load");
    cycle(1'b0, 1'b0, '0, 1'b1, "R6 marker in");
    shift_n(W - 2, 1'b0, "R6 marker travelling");
    cycle(1'b0, 1'b0, '0, 1'b0, "R6 marker at output");
    shift_n(2, 1'b0, "R6 marker gone");

    // R8: asynchronous clear mid-stream
    load('1, "R3 all ones");
    #2;
    rst_n = 1'b0;
    sel_n = 1'b1;
    #0.2;
    check("R8 async clear", ser_out, 1'b0);
    mdl.delete();
    for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    cur_exp = 1'b0;
    repeat (2) @(negedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    shift_n(W, 1'b0, "R8 stages cleared");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule